// File: doc/BRIEF.md
# Serial NOR Flash Command Slave

This block answers a serial NOR flash command set one byte at a time. A host-side serialiser (outside this block) hands it each byte shifted in while the active-low select is low. The block hands back the byte that must be shifted out on the following transfer. A small register-based array stands in for the flash cells. Its size, sector size, page size and the two sub-sector erase sizes are parameters.

Each command starts with an opcode. Read, page program and the three address-based erases then take a 24-bit address, sent most significant byte first. Reads stream bytes and wrap at the end of the array. Programming can only clear bits, unless the overwrite parameter is set, in which case the block behaves like an EEPROM. Erases fill an aligned region with 0xFF, and a sub-sector size is refused when its capability parameter is off. Write enable and write disable set and clear a latch that gates every program and erase. A status read and an identification read return prepared bytes.

The inbound byte stream uses valid/ready. `rx_ready` is high exactly while the select is low, so the block never stalls a selected transfer. A byte offered while deselected is not accepted. The outbound byte has no ready. `tx_valid` pulses for one cycle, one clock after each accepted byte, and the consumer must take it then.

Top module: `spi_nor_model`

## Requirements
- R1: Each byte accepted (`cs_n` low and `rx_valid` high) produces exactly one `tx_valid` pulse on the next clock with its response byte. `rx_ready` equals `!cs_n`. No byte is accepted while `cs_n` is high. Every response outside read and prepared-response phases is 0x00.
- R2: Opcodes 0x03 (read), 0x02 (program), 0xD8 (sector erase), 0x20 (small erase) and 0x52 (mid erase) take three following address bytes, most significant first. The address used is that 24-bit value modulo the array size.
- R3: After a read command, each transfer returns the byte at the current address and then advances the address by one, wrapping from the last byte to byte 0.
- R4: A programmed byte becomes old AND new, so bits only go from 1 to 0. When the `OVERWRITE` parameter is 1, the new byte replaces the old one.
- R5: During a program, the address advances within its page and wraps to the start of the same page after the page's last byte.
- R6: Opcode 0x06 sets the write-enable latch and 0x04 clears it. While the latch is clear, program bytes and erases leave the array unchanged. The status read (0x05) returns one byte with the latch in bit 1 and all other bits 0.
- R7: An erase fills with 0xFF the region of its granularity that contains the address, aligned down: one sector for 0xD8, `SMALL_ERASE_BYTES` for 0x20, `MID_ERASE_BYTES` for 0x52, and the whole array for 0xC7 (no address). Bytes outside the region keep their values.
- R8: A 0x20 or 0x52 erase whose capability parameter is 0 leaves the array unchanged and sets `erase_err`. `erase_err` then stays set until reset, whatever the latch state.
- R9: The identification read (0x9F) returns the 24-bit ID, most significant byte first. If `EXT_ID` is non-zero, it then returns the high and low bytes of `EXT_ID`. After the last byte, the next byte is decoded as an opcode.
- R10: Raising `cs_n` aborts any command in progress, and the first byte after reselection is decoded as an opcode.
- R11: Reset fills the array with 0xFF and clears the latch, `erase_err` and `tx_valid`.
- R12: An unknown opcode returns 0x00, and the next byte is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts the command |
| rx_valid | input | 1 | Inbound byte present |
| rx_ready | output | 1 | Inbound byte can be taken (equals !cs_n) |
| rx_data | input | 8 | Inbound byte |
| tx_valid | output | 1 | Response byte present, one cycle after acceptance |
| tx_data | output | 8 | Response byte |
| erase_err | output | 1 | Sticky flag: an unsupported erase size was requested |

## Verification
Every response byte is due on the clock after its inbound byte is accepted. The bench drives each byte on a falling edge and compares `tx_valid` and `tx_data` on the next falling edge, against a behavioural model that has just consumed the same byte. Array updates from program and erase take effect at that same edge, so the next read command already sees them. The bench confirms them through read streams rather than by looking inside. `erase_err` and `rx_ready` are compared at the falling edge after the triggering byte and while deselected. Idle cycles are checked for the absence of `tx_valid`.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;
  localparam logic [7:0] OP_WR_EN       = 8'h06;
  localparam logic [7:0] OP_WR_DIS      = 8'h04;
  localparam logic [7:0] OP_STATUS      = 8'h05;
  localparam logic [7:0] OP_IDENT       = 8'h9F;
  localparam logic [7:0] OP_READ        = 8'h03;
  localparam logic [7:0] OP_PROGRAM     = 8'h02;
  localparam logic [7:0] OP_ERASE_SEC   = 8'hD8;
  localparam logic [7:0] OP_ERASE_SMALL = 8'h20;
  localparam logic [7:0] OP_ERASE_MID   = 8'h52;
  localparam logic [7:0] OP_ERASE_CHIP  = 8'hC7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PROG,
    ST_READ,
    ST_RESP
  } nor_state_e;
endpackage

// File: rtl/nor_store.sv
module nor_store #(
  parameter int SIZE      = 512,
  parameter int AW        = 9,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          er_en,
  input  logic [AW-1:0] er_base,
  input  logic [AW-1:0] er_mask,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [SIZE];
  logic [7:0] merged;

  generate
    if (OVERWRITE) begin : g_overwrite
      assign merged = wr_data;
    end else begin : g_clear_only
      assign merged = mem[wr_idx] & wr_data;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SIZE; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < SIZE; i++) begin
        if (er_en && ((AW'(i) & ~er_mask) == er_base)) mem[i] <= 8'hFF;
      end
      if (wr_en) mem[wr_idx] <= merged;
    end
  end

  assign rd_data = mem[rd_idx];

  // R7: the addressed base byte reads erased after the erase edge
  assert_erase_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (er_en && !wr_en) |=> (mem[$past(er_base)] == 8'hFF));

  generate
    if (!OVERWRITE) begin : g_chk_clear
      // R4: programming never raises a bit
      assert_prog_no_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem[$past(wr_idx)] & ~$past(mem[wr_idx])) == 8'h00));
    end
  endgenerate
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import spi_nor_pkg::*;
#(
  parameter int          AW        = 9,
  parameter int          PAGE_W    = 6,
  parameter int          SECTOR_W  = 8,
  parameter int          SMALL_W   = 4,
  parameter int          MID_W     = 7,
  parameter bit          CAP_SMALL = 1'b1,
  parameter bit          CAP_MID   = 1'b1,
  parameter logic [23:0] JEDEC_ID  = 24'h5A1209,
  parameter logic [15:0] EXT_ID    = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          erase_err,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          er_en,
  output logic [AW-1:0] er_base,
  output logic [AW-1:0] er_mask,
  output logic [AW-1:0] rd_idx,
  input  logic [7:0]    rd_data
);
  localparam logic [AW-1:0] MASK_SEC   = AW'((1 << SECTOR_W) - 1);
  localparam logic [AW-1:0] MASK_SMALL = AW'((1 << SMALL_W) - 1);
  localparam logic [AW-1:0] MASK_MID   = AW'((1 << MID_W) - 1);
  localparam logic [2:0]    ID_LEN     = (EXT_ID != 16'h0000) ? 3'd5 : 3'd3;

  nor_state_e    state;
  logic [7:0]    op;
  logic [1:0]    cnt;
  logic [15:0]   abuf;
  logic [AW-1:0] addr;
  logic          wel;
  logic [2:0]    pos;
  logic [2:0]    rsp_len;

  logic          accept, addr_done, is_erase, supported, chip_hit;
  logic [AW-1:0] tgt, gran_mask, page_next;
  logic [7:0]    resp_byte;

  assign accept    = !cs_n && rx_valid;
  assign rx_ready  = !cs_n;
  assign addr_done = accept && (state == ST_ADDR) && (cnt == 2'd2);
  assign tgt       = AW'({abuf, rx_data});
  assign is_erase  = (op == OP_ERASE_SEC) || (op == OP_ERASE_SMALL) || (op == OP_ERASE_MID);
  assign chip_hit  = accept && (state == ST_IDLE) && (rx_data == OP_ERASE_CHIP);
  assign page_next = {addr[AW-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};

  always_comb begin
    gran_mask = MASK_SEC;
    supported = 1'b1;
    if (op == OP_ERASE_SMALL) begin
      gran_mask = MASK_SMALL;
      supported = CAP_SMALL;
    end else if (op == OP_ERASE_MID) begin
      gran_mask = MASK_MID;
      supported = CAP_MID;
    end
  end

  always_comb begin
    if (op == OP_STATUS) begin
      resp_byte = {6'b0, wel, 1'b0};
    end else begin
      case (pos)
        3'd0:    resp_byte = JEDEC_ID[23:16];
        3'd1:    resp_byte = JEDEC_ID[15:8];
        3'd2:    resp_byte = JEDEC_ID[7:0];
        3'd3:    resp_byte = EXT_ID[15:8];
        3'd4:    resp_byte = EXT_ID[7:0];
        default: resp_byte = 8'h00;
      endcase
    end
  end

  assign wr_en   = accept && (state == ST_PROG) && wel;
  assign wr_idx  = addr;
  assign wr_data = rx_data;
  assign er_en   = wel && ((addr_done && is_erase && supported) || chip_hit);
  assign er_mask = chip_hit ? '1 : gran_mask;
  assign er_base = chip_hit ? '0 : (tgt & ~gran_mask);
  assign rd_idx  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op        <= 8'h00;
      cnt       <= 2'd0;
      abuf      <= 16'h0000;
      addr      <= '0;
      wel       <= 1'b0;
      pos       <= 3'd0;
      rsp_len   <= 3'd0;
      erase_err <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= 8'h00;
    end else begin
      tx_valid <= accept;
      if (addr_done && is_erase && !supported) erase_err <= 1'b1;
      if (cs_n) begin
        state <= ST_IDLE;
      end else if (rx_valid) begin
        tx_data <= 8'h00;
        case (state)
          ST_IDLE: begin
            op  <= rx_data;
            cnt <= 2'd0;
            pos <= 3'd0;
            case (rx_data)
              OP_WR_EN:  wel <= 1'b1;
              OP_WR_DIS: wel <= 1'b0;
              OP_STATUS: begin
                rsp_len <= 3'd1;
                state   <= ST_RESP;
              end
              OP_IDENT: begin
                rsp_len <= ID_LEN;
                state   <= ST_RESP;
              end
              OP_READ, OP_PROGRAM, OP_ERASE_SEC, OP_ERASE_SMALL, OP_ERASE_MID:
                state <= ST_ADDR;
              default: state <= ST_IDLE;
            endcase
          end
          ST_ADDR: begin
            abuf <= {abuf[7:0], rx_data};
            cnt  <= cnt + 2'd1;
            if (cnt == 2'd2) begin
              addr <= tgt;
              if (op == OP_READ)         state <= ST_READ;
              else if (op == OP_PROGRAM) state <= ST_PROG;
              else                       state <= ST_IDLE;
            end
          end
          ST_PROG: addr <= page_next;
          ST_READ: begin
            tx_data <= rd_data;
            addr    <= addr + AW'(1);
          end
          ST_RESP: begin
            tx_data <= resp_byte;
            pos     <= pos + 3'd1;
            if (pos == rsp_len - 3'd1) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: every accepted byte yields a response pulse on the next edge
  assert_resp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tx_valid);
  // R10: deselect returns the sequencer to opcode decode
  assert_deselect_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (state == ST_IDLE));
  // R6: write enable opcode sets the latch
  assert_wel_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (state == ST_IDLE) && (rx_data == OP_WR_EN)) |=> wel);
  // R8: error flag never clears once raised
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_err |=> erase_err);
  // R3: read stream advances by one per byte
  assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (state == ST_READ)) |=> (addr == $past(addr) + AW'(1)));
  // R5: program stays inside its page
  assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (state == ST_PROG)) |=> (addr[AW-1:PAGE_W] == $past(addr[AW-1:PAGE_W])));
endmodule

// File: rtl/spi_nor_model.sv
module spi_nor_model #(
  parameter int          SECTOR_BYTES      = 256,
  parameter int          NUM_SECTORS       = 2,
  parameter int          PAGE_BYTES        = 64,
  parameter int          SMALL_ERASE_BYTES = 16,
  parameter int          MID_ERASE_BYTES   = 128,
  parameter bit          CAP_SMALL         = 1'b1,
  parameter bit          CAP_MID           = 1'b1,
  parameter bit          OVERWRITE         = 1'b0,
  parameter logic [23:0] JEDEC_ID          = 24'h5A1209,
  parameter logic [15:0] EXT_ID            = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       erase_err
);
  localparam int SIZE     = SECTOR_BYTES * NUM_SECTORS;
  localparam int AW       = $clog2(SIZE);
  localparam int PAGE_W   = $clog2(PAGE_BYTES);
  localparam int SECTOR_W = $clog2(SECTOR_BYTES);
  localparam int SMALL_W  = $clog2(SMALL_ERASE_BYTES);
  localparam int MID_W    = $clog2(MID_ERASE_BYTES);

  logic          wr_en, er_en;
  logic [AW-1:0] wr_idx, er_base, er_mask, rd_idx;
  logic [7:0]    wr_data, rd_data;

  nor_cmd_ctrl #(
    .AW(AW), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W), .SMALL_W(SMALL_W), .MID_W(MID_W),
    .CAP_SMALL(CAP_SMALL), .CAP_MID(CAP_MID), .JEDEC_ID(JEDEC_ID), .EXT_ID(EXT_ID)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data), .erase_err(erase_err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .er_en(er_en),
    .er_base(er_base), .er_mask(er_mask), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  nor_store #(.SIZE(SIZE), .AW(AW), .OVERWRITE(OVERWRITE)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .er_en(er_en), .er_base(er_base), .er_mask(er_mask), .rd_idx(rd_idx),
    .rd_data(rd_data)
  );
endmodule

// File: tb/spi_nor_model_tb.sv
`timescale 1ns/1ps
module spi_nor_model_tb;
  localparam int SZ = 512;

  logic clk = 1'b0;
  logic rst_n, cs_n, rx_valid;
  logic [7:0] rx_data;
  logic rdy_a, txv_a, err_a, rdy_b, txv_b, err_b;
  logic [7:0] txd_a, txd_b;

  always #2 clk = ~clk;

  spi_nor_model #(.CAP_MID(1'b1), .OVERWRITE(1'b0), .EXT_ID(16'h4D01)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_ready(rdy_a),
    .rx_data(rx_data), .tx_valid(txv_a), .tx_data(txd_a), .erase_err(err_a));

  spi_nor_model #(.CAP_MID(1'b0), .OVERWRITE(1'b1), .EXT_ID(16'h4D01)) u_dut_ovw (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_ready(rdy_b),
    .rx_data(rx_data), .tx_valid(txv_b), .tx_data(txd_b), .erase_err(err_b));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int mem [2][SZ];
  int m_err [2];
  int cap_mid [2] = '{1, 0};
  int ovw [2] = '{0, 1};
  int idb [5] = '{8'h5A, 8'h12, 8'h09, 8'h4D, 8'h01};
  int m_st, m_op, m_cnt, m_abuf, m_addr, m_wel, m_pos, m_len;

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic fill(int k, int base, int len);
    for (int i = base; i < base + len; i++) mem[k][i] = 8'hFF;
  endtask

  task automatic xfer(input int b, input string tag);
    int e [2];
    int g;
    e = '{0, 0};
    case (m_st)
      0: begin
        m_op = b; m_cnt = 0; m_abuf = 0; m_pos = 0;
        case (b)
          8'h06: m_wel = 1;
          8'h04: m_wel = 0;
          8'h05: begin m_st = 4; m_len = 1; end
          8'h9F: begin m_st = 4; m_len = 5; end
          8'h03, 8'h02, 8'hD8, 8'h20, 8'h52: m_st = 1;
          8'hC7: if (m_wel != 0) for (int k = 0; k < 2; k++) fill(k, 0, SZ);
          default: ;
        endcase
      end
      1: begin
        m_abuf = (m_abuf << 8) | b;
        m_cnt++;
        if (m_cnt == 3) begin
          m_addr = m_abuf % SZ;
          if (m_op == 8'h03) m_st = 3;
          else if (m_op == 8'h02) m_st = 2;
          else begin
            g = (m_op == 8'hD8) ? 256 : (m_op == 8'h20) ? 16 : 128;
            for (int k = 0; k < 2; k++) begin
              if (m_op == 8'h52 && cap_mid[k] == 0) m_err[k] = 1;
              else if (m_wel != 0) fill(k, m_addr - (m_addr % g), g);
            end
            m_st = 0;
          end
        end
      end
      2: begin
        if (m_wel != 0)
          for (int k = 0; k < 2; k++)
            mem[k][m_addr] = (ovw[k] != 0) ? b : (mem[k][m_addr] & b);
        m_addr = (m_addr / 64) * 64 + ((m_addr + 1) % 64);
      end
      3: begin
        e[0] = mem[0][m_addr]; e[1] = mem[1][m_addr];
        m_addr = (m_addr + 1) % SZ;
      end
      default: begin
        e[0] = (m_op == 8'h05) ? m_wel * 2 : idb[m_pos];
        e[1] = e[0];
        m_pos++;
        if (m_pos == m_len) m_st = 0;
      end
    endcase
    rx_valid = 1'b1;
    rx_data = 8'(b);
    @(negedge clk);
    check({tag, " valid"}, int'(txv_a), 1);
    check({tag, " valid ovw"}, int'(txv_b), 1);
    check({tag, " data"}, int'(txd_a), e[0]);
    check({tag, " data ovw"}, int'(txd_b), e[1]);
    check({tag, " err"}, int'(err_a), m_err[0]);
    check({tag, " err ovw"}, int'(err_b), m_err[1]);
    rx_valid = 1'b0;
  endtask

  task automatic acmd(input int op, input int a, input string tag);
    xfer(op, tag);
    xfer((a >> 16) & 8'hFF, tag);
    xfer((a >> 8) & 8'hFF, tag);
    xfer(a & 8'hFF, tag);
  endtask

  task automatic rd(input int a, input int n, input string tag);
    acmd(8'h03, a, tag);
    for (int i = 0; i < n; i++) xfer(8'h00, tag);
    desel(tag);
  endtask

  task automatic desel(input string tag);
    cs_n = 1'b1;
    rx_valid = 1'b1;
    rx_data = 8'h05;
    m_st = 0;
    #1;
    check({tag, " R1 ready low"}, int'(rdy_a | rdy_b), 0);
    @(negedge clk);
    check({tag, " R1 no accept"}, int'(txv_a | txv_b), 0);
    rx_valid = 1'b0;
    cs_n = 1'b0;
    @(negedge clk);
    check({tag, " R1 idle"}, int'(txv_a | txv_b), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rx_valid = 1'b0; rx_data = 8'h00;
    m_st = 0; m_wel = 0; m_addr = 0; m_op = 0; m_pos = 0; m_len = 0;
    m_err[0] = 0; m_err[1] = 0;
    for (int k = 0; k < 2; k++) fill(k, 0, SZ);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 tx_valid", int'(txv_a | txv_b), 0);
    check("R11 err", int'(err_a | err_b), 0);
    cs_n = 1'b0;
    @(negedge clk);
    rd(0, 2, "R11 R2 erased read");

    // R6: latch and status
    xfer(8'h05, "R6 status"); xfer(8'h00, "R6 status clear"); desel("R6");
    xfer(8'h06, "R6 wren"); desel("R6");
    xfer(8'h05, "R6 status"); xfer(8'h00, "R6 status set"); desel("R6");
    xfer(8'h04, "R6 wrdi"); xfer(8'h05, "R6 status"); xfer(8'h00, "R6 status off"); desel("R6");
    acmd(8'h02, 16'h0010, "R6 prog locked"); xfer(8'hAA, "R6 prog locked"); desel("R6");
    rd(16'h0010, 1, "R6 locked readback");

    // R4: AND vs overwrite
    xfer(8'h06, "R4 wren"); desel("R4");
    acmd(8'h02, 16'h0010, "R4 prog"); xfer(8'hA5, "R4"); xfer(8'h3C, "R4"); desel("R4");
    acmd(8'h02, 16'h0010, "R4 reprog"); xfer(8'h0F, "R4"); desel("R4");
    rd(16'h0010, 2, "R4 readback");

    // R5: page wrap
    acmd(8'h02, 16'h003F, "R5 prog"); xfer(8'h11, "R5"); xfer(8'h22, "R5"); desel("R5");
    rd(16'h003E, 3, "R5 readback");
    rd(16'h0000, 1, "R5 page start");

    // R3 and R2: read wrap, upper address bits fold
    rd(16'h01FF, 3, "R3 wrap");
    rd(24'h040000, 1, "R2 fold");

    // R9 and R12: identification then unknown opcode
    xfer(8'h9F, "R9 id");
    for (int i = 0; i < 5; i++) xfer(8'h00, "R9 id byte");
    xfer(8'h00, "R12 unknown");
    xfer(8'hE7, "R12 unknown");
    xfer(8'h05, "R12 decode after"); xfer(8'h00, "R12 status"); desel("R12");

    // R7: small erase with alignment
    acmd(8'h02, 16'h001E, "R7 prog"); for (int i = 0; i < 4; i++) xfer(8'h00, "R7"); desel("R7");
    acmd(8'h20, 16'h0025, "R7 small erase"); desel("R7");
    rd(16'h001C, 8, "R7 small readback");

    // R8: mid erase refused on the instance lacking it
    acmd(8'h02, 16'h0080, "R8 prog"); xfer(8'h00, "R8"); desel("R8");
    acmd(8'h02, 16'h0100, "R8 prog"); xfer(8'h00, "R8"); desel("R8");
    acmd(8'h52, 16'h00C0, "R8 mid erase"); desel("R8");
    rd(16'h007F, 3, "R8 R7 mid readback");

    // R7: sector erase
    acmd(8'hD8, 16'h01AB, "R7 sector erase"); desel("R7");
    rd(16'h00FF, 2, "R7 sector readback");

    // R6: chip erase blocked by latch, then R7 chip erase
    xfer(8'h04, "R6 wrdi"); desel("R6");
    xfer(8'hC7, "R6 chip locked"); desel("R6");
    acmd(8'h20, 16'h0000, "R6 erase locked"); desel("R6");
    rd(16'h0000, 1, "R6 chip locked readback");
    xfer(8'h06, "R7 wren"); desel("R7");
    xfer(8'hC7, "R7 chip erase"); desel("R7");
    rd(16'h0000, 1, "R7 chip readback");
    rd(16'h0010, 2, "R7 chip readback");

    // R10: abort mid-address
    xfer(8'h03, "R10"); xfer(8'h00, "R10"); xfer(8'h00, "R10"); desel("R10");
    xfer(8'h05, "R10 decode"); xfer(8'h00, "R10 status"); desel("R10");

    // R8: sticky across later commands
    rd(16'h0000, 1, "R8 sticky");
    check("R8 sticky err ovw", int'(err_b), 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule